// File: doc/BRIEF.md
# Shift-Register Operand Stack

This block is a small last-in-first-out store for the operands of a narrow calculator datapath. Its entries sit in a fixed row of registers that all move together. The newest entry always lives in slot 0, so the top-of-stack output is a plain wire from that register, with no pointer and no read multiplexer.

On each rising clock edge a 2-bit operation code picks what happens. Two of the codes leave the contents alone. One code pushes the data input in at the top, and every older entry moves one slot deeper. The last code pops: every entry moves one slot toward the top, and zero fills the deepest slot. Pushing onto a full stack silently drops the deepest entry. Popping an empty stack just shifts in more zeros. An asynchronous active-high reset clears all slots at once.

Top module: `opstk_top`

## Requirements
- R1: While reset is high, every slot is zero and the top output reads 0, whether or not the clock runs.
- R2: Operation codes 0 (2'b00) and 1 (2'b01) leave every slot unchanged at the clock edge.
- R3: Operation code 2 (2'b10) puts the data input into slot 0 and moves each slot k to slot k+1.
- R4: On a push with all DEPTH slots in use, the value in the deepest slot (DEPTH-1) is discarded.
- R5: Operation code 3 (2'b11) moves each slot k+1 to slot k and loads zero into the deepest slot.
- R6: A pop when fewer entries are held than slots, including an empty stack, returns zeros from below the last real entry.
- R7: The top output equals slot 0 at all times, including during the cycle after any update.
- R8: The default configuration has WIDTH=5 and DEPTH=4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high clear |
| op | input | 2 | 0/1 hold, 2 push, 3 pop |
| push_val | input | WIDTH | Value entered on push |
| top_val | output | WIDTH | Current contents of slot 0 |

## Verification
The stack is exercised with runs of pushes that go deeper than four entries. Because the fifth value must evict the first, these runs show whether the deepest slot is dropped or wrongly kept. Runs of pops past empty show whether zero refills the bottom, as opposed to a stale or wrapped value. Holds under both hold codes are interleaved with a changing data input to expose any leak of the input into the store. Long random mixes of all four codes are then compared after every edge against a bench model of the stack. A reset asserted in the middle of a cycle confirms that clearing does not wait for the clock.

// File: rtl/opstk_pkg.sv
package opstk_pkg;
   typedef enum logic [1:0] {
      OP_HOLD0 = 2'b00,
      OP_HOLD1 = 2'b01,
      OP_PUSH  = 2'b10,
      OP_POP   = 2'b11
   } opstk_op_e;
endpackage

// File: rtl/opstk_slot.sv
module opstk_slot #(
   parameter int WIDTH = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] nxt,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or posedge rst) begin
      if (rst)       q <= '0;
      else if (load) q <= nxt;
   end
endmodule

// File: rtl/opstk_top.sv
module opstk_top
   import opstk_pkg::*;
#(
   parameter int WIDTH = 5,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       op,
   input  logic [WIDTH-1:0] push_val,
   output logic [WIDTH-1:0] top_val
);
   localparam int LAST = DEPTH - 1;

   initial begin
      a_cfg_width_r8 : assert (WIDTH >= 1) else $error("WIDTH must be positive");
      a_cfg_depth_r8 : assert (DEPTH >= 2) else $error("DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] slot [DEPTH];
   logic [WIDTH-1:0] nxt  [DEPTH];
   logic             is_push, is_pop, shift_en;

   always_comb begin
      is_push  = (op == OP_PUSH);
      is_pop   = (op == OP_POP);
      shift_en = is_push | is_pop;
   end

   for (genvar k = 0; k < DEPTH; k++) begin : g_slot
      if (k == 0) begin : g_top
         assign nxt[k] = is_push ? push_val : slot[k+1];
      end else if (k == LAST) begin : g_bot
         assign nxt[k] = is_push ? slot[k-1] : '0;
      end else begin : g_mid
         assign nxt[k] = is_push ? slot[k-1] : slot[k+1];
      end
      opstk_slot #(.WIDTH(WIDTH)) u_slot (
         .clk (clk),
         .rst (rst),
         .load(shift_en),
         .nxt (nxt[k]),
         .q   (slot[k])
      );
   end

   assign top_val = slot[0];

   // R2 hold leaves top unchanged
   p_hold_keeps_r2 : assert property (@(posedge clk) disable iff (rst)
      (op[1] == 1'b0) |=> $stable(top_val));
   // R3 push places input on top
   p_push_top_r3 : assert property (@(posedge clk) disable iff (rst)
      (op == OP_PUSH) |=> (top_val == $past(push_val)));
   // R4 push moves deepest-but-one into deepest
   p_push_deep_r4 : assert property (@(posedge clk) disable iff (rst)
      (op == OP_PUSH) |=> (slot[LAST] == $past(slot[LAST-1])));
   // R5 pop brings slot 1 to top
   p_pop_top_r5 : assert property (@(posedge clk) disable iff (rst)
      (op == OP_POP) |=> (top_val == $past(slot[1])));
   // R6 pop fills bottom with zero
   p_pop_zero_r6 : assert property (@(posedge clk) disable iff (rst)
      (op == OP_POP) |=> (slot[LAST] == '0));
   // R1 reset clears top
   p_reset_clear_r1 : assert property (@(posedge clk)
      rst |-> (top_val == '0));
endmodule

// File: tb/sim_opstk_top.sv
module sim_opstk_top;
   localparam int W = 5;
   localparam int D = 4;

   logic         clk = 1'b0;
   logic         rst;
   logic [1:0]   op;
   logic [W-1:0] push_val;
   logic [W-1:0] top_val;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] model [D];

   always #5 clk = ~clk;

   opstk_top #(.WIDTH(W), .DEPTH(D)) u0 (
      .clk(clk), .rst(rst), .op(op), .push_val(push_val), .top_val(top_val)
   );

   function automatic logic [W-1:0] ref_top();
      return model[0];
   endfunction

   task automatic model_step(input logic [1:0] o, input logic [W-1:0] v);
      if (o == 2'b10) begin
         for (int k = D-1; k > 0; k--) model[k] = model[k-1];
         model[0] = v;
      end else if (o == 2'b11) begin
         for (int k = 0; k < D-1; k++) model[k] = model[k+1];
         model[D-1] = '0;
      end
   endtask

   task automatic check(input string req, input logic [W-1:0] exp);
      checks++;
      if (top_val !== exp) begin
         errors++;
         $display("FAIL %s top_val=%0d expected=%0d", req, top_val, exp);
      end
   endtask

   // drive on falling edge, sample after next falling edge
   task automatic step(input logic [1:0] o, input logic [W-1:0] v, input string req);
      op = o; push_val = v;
      @(posedge clk);
      model_step(o, v);
      @(negedge clk);
      check(req, ref_top());
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd77));
      for (int k = 0; k < D; k++) model[k] = '0;
      rst = 1'b1; op = 2'b10; push_val = 5'd31;
      repeat (2) @(negedge clk);
      check("R1 reset", 5'd0);
      rst = 1'b0;
      // R3/R4 pushes past full
      step(2'b10, 5'd1, "R3 push");
      step(2'b10, 5'd2, "R3 push");
      step(2'b10, 5'd3, "R3 push");
      step(2'b10, 5'd4, "R3 push");
      step(2'b10, 5'd5, "R4 push full");
      // R2 holds with varying input
      step(2'b00, 5'd17, "R2 hold0");
      step(2'b01, 5'd9, "R2 hold1");
      // R5/R4 pops: 4,3,2 then zero (1 was evicted)
      step(2'b11, 5'd0, "R5 pop");
      step(2'b11, 5'd0, "R5 pop");
      step(2'b11, 5'd0, "R5 pop");
      step(2'b11, 5'd0, "R4 evicted gives zero");
      // R6 pop past empty
      step(2'b11, 5'd0, "R6 pop empty");
      step(2'b11, 5'd0, "R6 pop empty");
      // R7 R8 random mix against model
      for (int i = 0; i < 400; i++) begin
         logic [1:0] o;
         o = 2'($urandom_range(0, 3));
         step(o, 5'($urandom), "R7 random");
      end
      // R1 asynchronous reset mid-cycle
      step(2'b10, 5'd21, "R3 push");
      #2 rst = 1'b1;
      #1 check("R1 async", 5'd0);
      for (int k = 0; k < D; k++) model[k] = '0;
      @(negedge clk); rst = 1'b0;
      step(2'b00, 5'd3, "R2 hold after reset");
      step(2'b11, 5'd0, "R8 depth pop");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule